// File: doc/BRIEF.md
# Power Management Event Input Conditioner

This block sits between the board-level power management inputs and the interrupt and wake logic of a system controller. It takes six inputs: a power button, a sleep button, a lid switch, a modem ring indicator, a thermal alarm and an external SMI line. Every input is first brought into the clock domain through a two-flop synchroniser. The power button and the lid switch can then pass through a fixed-time debounce filter, which one global enable turns on or off. After that, an edge detector turns each conditioned level into a one-cycle event.

Each event sets a sticky status bit, and software clears that bit by writing 1 to it. Two per-source enable masks select which status bits drive the SMI request and which drive the wake request. The external SMI line is qualified: it must stay low for a minimum number of clocks before it counts. The same pin is driven low, open-drain style, for a fixed number of clocks whenever the serial interrupt path reports an SMI. An asserted thermal input, when its enable is set, produces a level throttle request for the stop-clock generator that lies outside this block.

Top module: `pm_event_cond`

## Requirements
- R1: Status bit positions are: bit 0 power button, bit 1 sleep button, bit 2 lid, bit 3 ring, bit 4 thermal, bit 5 external SMI. With debounce off, a power button press (pwr_btn_n falling) sets status[0] on the third rising clock edge after the pin changes, and not earlier.
- R2: With dbnc_en=1, the power button and lid levels change only after the synchronised input has held its new level for DB cycles, where DB = CLK_HZ*DB_US/1e6. A press shorter than DB cycles sets no status, and a held press sets status[0] on edge DB+3.
- R3: lid_mode selects the lid event: 0 none, 1 lid_i rising, 2 lid_i falling, 3 both edges. The chosen transitions set status[2] and the others do not.
- R4: A sleep button press sets status[1] only while slp_acpi_en=1. slp_gpi always shows the synchronised pressed level (1 while pressed), whatever slp_acpi_en is set to.
- R5: A falling ring_n sets status[3], and the ring source can raise wake_req.
- R6: The external SMI line sets status[5] only when xsmi_pin_n stays low for at least XSMI_MIN_LOW consecutive cycles. A shorter low pulse is ignored, and a long low produces a single event.
- R7: Status bits are sticky. A write with clr_wr=1 clears the bits that are 1 in clr_data and leaves the others alone. An event in the same cycle as its clear wins, so the bit stays set.
- R8: smi_req is 1 exactly when some status bit and the matching smi_en bit are both 1. wake_req follows the same rule with wake_en.
- R9: A one-cycle serirq_smi pulse holds xsmi_drive_low at 1 for exactly XSMI_HOLD cycles, starting at the next clock edge.
- R10: throttle_req is 1 while the synchronised thermal input is asserted and thrm_thr_en=1, two edges after thrm_n falls. A falling thrm_n also sets status[4].
- R11: After reset, status, smi_req, wake_req, throttle_req and xsmi_drive_low are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (PCI clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| pwr_btn_n | input | 1 | Power button, low when pressed |
| slp_btn_n | input | 1 | Sleep button, low when pressed |
| lid_i | input | 1 | Lid switch level |
| ring_n | input | 1 | Ring indicator, low when active |
| thrm_n | input | 1 | Thermal alarm, low when active |
| xsmi_pin_n | input | 1 | Sensed level of the external SMI pin |
| serirq_smi | input | 1 | SMI pulse from the serial interrupt path |
| dbnc_en | input | 1 | Global debounce enable for power button and lid |
| lid_mode | input | 2 | Lid edge select (0 none, 1 rise, 2 fall, 3 both) |
| slp_acpi_en | input | 1 | Sleep button treated as a sleep event |
| thrm_thr_en | input | 1 | Thermal throttle enable |
| smi_en | input | 6 | Per-source SMI enables |
| wake_en | input | 6 | Per-source wake enables |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 6 | Write-1-to-clear mask |
| status | output | 6 | Sticky event status |
| slp_gpi | output | 1 | Plain synchronised sleep button level |
| smi_req | output | 1 | SMI request |
| wake_req | output | 1 | Wake request |
| throttle_req | output | 1 | Thermal throttle request |
| xsmi_drive_low | output | 1 | Open-drain pull-down enable for the SMI pin |

## Verification
A debounce counter that is wrong shows up as a power or lid status bit that rises one or more edges away from edge DB+3, or that rises after a press shorter than DB cycles. The bench sweeps the press length across that boundary. A bad low-width qualifier is caught the same way: the bench sweeps external SMI pulse lengths across XSMI_MIN_LOW, and a fault makes status[5] wrong within a few cycles of the pulse. A fault in the sticky register or in the enable gating shows at once on smi_req and wake_req, because every enable mask is swept against a known status pattern.

// File: rtl/pm_event_pkg.sv
`timescale 1ns/1ps
package pm_event_pkg;

    localparam int NSRC     = 6;
    localparam int SRC_PWR  = 0;
    localparam int SRC_SLP  = 1;
    localparam int SRC_LID  = 2;
    localparam int SRC_RING = 3;
    localparam int SRC_THRM = 4;
    localparam int SRC_XSMI = 5;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // Debounce length in clocks for a given clock rate and time in microseconds.
    function automatic int db_cycles(input longint clk_hz, input longint us);
        longint c;
        c = (clk_hz * us) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    // Sources that may be routed through the debounce filter.
    function automatic bit has_debounce(input int idx);
        return (idx == SRC_PWR) || (idx == SRC_LID);
    endfunction

endpackage

// File: rtl/pm_sync2.sv
`timescale 1ns/1ps
module pm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pm_debounce.sv
`timescale 1ns/1ps
module pm_debounce #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic          filt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (!en) begin
            // follow the input so that enabling the filter causes no jump
            filt <= d;
            cnt  <= '0;
        end else if (d != filt) begin
            if (cnt == LAST) begin
                filt <= d;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign q = en ? filt : d;
endmodule

// File: rtl/pm_edge_det.sv
`timescale 1ns/1ps
module pm_edge_det
    import pm_event_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  edge_mode_e mode,
    output logic       evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        unique case (mode)
            EDGE_RISE: evt = lvl & ~prev;
            EDGE_FALL: evt = ~lvl & prev;
            EDGE_BOTH: evt = lvl ^ prev;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_low_qual.sv
`timescale 1ns/1ps
module pm_low_qual #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic evt
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (!lvl)      cnt <= '0;
        else if (cnt != SAT) cnt <= cnt + 1'b1;
    end

    // one event per low period, once the minimum width is reached
    assign evt = lvl && (cnt == LAST);
endmodule

// File: rtl/pm_event_cond.sv
`timescale 1ns/1ps
module pm_event_cond
    import pm_event_pkg::*;
#(
    parameter int CLK_HZ       = 33_000_000,
    parameter int DB_US        = 200,
    parameter int XSMI_MIN_LOW = 4,
    parameter int XSMI_HOLD    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_btn_n,
    input  logic            slp_btn_n,
    input  logic            lid_i,
    input  logic            ring_n,
    input  logic            thrm_n,
    input  logic            xsmi_pin_n,
    input  logic            serirq_smi,
    input  logic            dbnc_en,
    input  logic [1:0]      lid_mode,
    input  logic            slp_acpi_en,
    input  logic            thrm_thr_en,
    input  logic [NSRC-1:0] smi_en,
    input  logic [NSRC-1:0] wake_en,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_data,
    output logic [NSRC-1:0] status,
    output logic            slp_gpi,
    output logic            smi_req,
    output logic            wake_req,
    output logic            throttle_req,
    output logic            xsmi_drive_low
);
    localparam int DB_CYC = db_cycles(longint'(CLK_HZ), longint'(DB_US));
    localparam int HW     = $clog2(XSMI_HOLD + 1);

    src_vec_t raw_act;   // active-high view of the pins
    src_vec_t syn;       // synchronised
    src_vec_t cond;      // after optional debounce
    src_vec_t evt;       // one-cycle events
    src_vec_t evt_raw;
    src_vec_t clr_mask;
    logic [HW-1:0] hold_cnt;

    assign raw_act[SRC_PWR]  = ~pwr_btn_n;
    assign raw_act[SRC_SLP]  = ~slp_btn_n;
    assign raw_act[SRC_LID]  = lid_i;
    assign raw_act[SRC_RING] = ~ring_n;
    assign raw_act[SRC_THRM] = ~thrm_n;
    assign raw_act[SRC_XSMI] = ~xsmi_pin_n;

    pm_sync2 #(.W(NSRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_act),
        .q   (syn)
    );

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_src
            if (has_debounce(i)) begin : g_db
                pm_debounce #(.CYCLES(DB_CYC)) u_db (
                    .clk (clk),
                    .rst (rst),
                    .en  (dbnc_en),
                    .d   (syn[i]),
                    .q   (cond[i])
                );
            end else begin : g_nodb
                assign cond[i] = syn[i];
            end

            if (i == SRC_XSMI) begin : g_qual
                pm_low_qual #(.MIN_LOW(XSMI_MIN_LOW)) u_q (
                    .clk (clk),
                    .rst (rst),
                    .lvl (cond[i]),
                    .evt (evt_raw[i])
                );
            end else begin : g_edge
                edge_mode_e md;
                assign md = (i == SRC_LID) ? edge_mode_e'(lid_mode) : EDGE_RISE;
                pm_edge_det u_ed (
                    .clk  (clk),
                    .rst  (rst),
                    .lvl  (cond[i]),
                    .mode (md),
                    .evt  (evt_raw[i])
                );
            end
        end
    endgenerate

    // sleep button is only an event source when its ACPI role is enabled
    always_comb begin
        evt          = evt_raw;
        evt[SRC_SLP] = evt_raw[SRC_SLP] & slp_acpi_en;
    end

    assign clr_mask = clr_wr ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | evt;
    end

    assign smi_req      = |(status & smi_en);
    assign wake_req     = |(status & wake_en);
    assign slp_gpi      = syn[SRC_SLP];
    assign throttle_req = syn[SRC_THRM] & thrm_thr_en;

    // open-drain pull-down of the SMI pin for serial-IRQ SMIs
    always_ff @(posedge clk) begin
        if (rst)                hold_cnt <= '0;
        else if (serirq_smi)    hold_cnt <= HW'(XSMI_HOLD);
        else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
    end

    assign xsmi_drive_low = (hold_cnt != '0);
endmodule

// File: rtl/pm_event_cond_chk.sv
`timescale 1ns/1ps
module pm_event_cond_chk #(
    parameter int N = 6
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] evt,
    input logic [N-1:0] status,
    input logic         clr_wr,
    input logic [N-1:0] clr_data,
    input logic         xsmi_pin_n,
    input logic         serirq_smi,
    input logic         xsmi_drive_low
);
    logic [N-1:0] clr_m;
    assign clr_m = clr_wr ? clr_data : '0;

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~status & $past(status) & ~$past(clr_m)) == '0));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(clr_data & ~evt)) == '0));

    // R1
    status_cause_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));

    // R6
    xsmi_min_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt[N-1] |-> (!$past(xsmi_pin_n, 2) && !$past(xsmi_pin_n, 5)));

    // R9
    xsmi_drive_chk: assert property (@(posedge clk) disable iff (rst)
        serirq_smi |=> xsmi_drive_low);
endmodule

bind pm_event_cond pm_event_cond_chk #(.N(pm_event_pkg::NSRC)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .evt            (evt),
    .status         (status),
    .clr_wr         (clr_wr),
    .clr_data       (clr_data),
    .xsmi_pin_n     (xsmi_pin_n),
    .serirq_smi     (serirq_smi),
    .xsmi_drive_low (xsmi_drive_low)
);

// File: tb/tb_pm_event_cond.sv
`timescale 1ns/1ps
module tb_pm_event_cond;
    localparam int DB   = 8;   // 1 MHz * 8 us
    localparam int MINL = 4;
    localparam int HOLD = 3;

    logic clk = 0, rst = 1;
    logic pwr_btn_n = 1, slp_btn_n = 1, lid_i = 0, ring_n = 1, thrm_n = 1, xsmi_pin_n = 1;
    logic serirq_smi = 0, dbnc_en = 0, slp_acpi_en = 0, thrm_thr_en = 0, clr_wr = 0;
    logic [1:0] lid_mode = 0;
    logic [5:0] smi_en = 0, wake_en = 0, clr_data = 0;
    logic [5:0] status;
    logic slp_gpi, smi_req, wake_req, throttle_req, xsmi_drive_low;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pm_event_cond #(.CLK_HZ(1_000_000), .DB_US(8), .XSMI_MIN_LOW(MINL), .XSMI_HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .pwr_btn_n(pwr_btn_n), .slp_btn_n(slp_btn_n), .lid_i(lid_i),
        .ring_n(ring_n), .thrm_n(thrm_n), .xsmi_pin_n(xsmi_pin_n), .serirq_smi(serirq_smi),
        .dbnc_en(dbnc_en), .lid_mode(lid_mode), .slp_acpi_en(slp_acpi_en),
        .thrm_thr_en(thrm_thr_en), .smi_en(smi_en), .wake_en(wake_en), .clr_wr(clr_wr),
        .clr_data(clr_data), .status(status), .slp_gpi(slp_gpi), .smi_req(smi_req),
        .wake_req(wake_req), .throttle_req(throttle_req), .xsmi_drive_low(xsmi_drive_low)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_data = 6'h3f;
        step(1);
        clr_wr = 0; clr_data = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R11 reset state
        chk("R11 status", status, 0);
        chk("R11 smi", smi_req, 0);
        chk("R11 wake", wake_req, 0);
        chk("R11 thr", throttle_req, 0);
        chk("R11 drv", xsmi_drive_low, 0);

        // R1 latency without debounce
        smi_en = 6'h3f;
        pwr_btn_n = 0;
        step(2); chk("R1 early", status[0], 0);
        step(1); chk("R1 set", status[0], 1);
        chk("R8 smi on", smi_req, 1);
        smi_en = 6'h3e; #1 chk("R8 smi masked", smi_req, 0);
        pwr_btn_n = 1; step(4); clear_all();

        // R7 set wins over clear, selective clear
        pwr_btn_n = 0; step(2);
        clr_wr = 1; clr_data = 6'h01; step(1); clr_wr = 0; clr_data = 0;
        chk("R7 set wins", status[0], 1);
        pwr_btn_n = 1; step(3);
        clr_wr = 1; clr_data = 6'h02; step(1); clr_wr = 0;
        chk("R7 other bit", status[0], 1);
        clr_wr = 1; clr_data = 6'h01; step(1); clr_wr = 0; clr_data = 0;
        chk("R7 cleared", status[0], 0);

        // R2 debounce: press length sweep and exact latency
        dbnc_en = 1;
        for (int L = 1; L <= DB + 2; L++) begin
            pwr_btn_n = 0; step(L);
            pwr_btn_n = 1; step(2 * DB + 6);
            chk($sformatf("R2 len%0d", L), status[0], (L >= DB) ? 1 : 0);
            clear_all();
        end
        pwr_btn_n = 0;
        step(DB + 2); chk("R2 early", status[0], 0);
        step(1);      chk("R2 edge", status[0], 1);
        pwr_btn_n = 1; step(2 * DB + 6); clear_all();
        lid_mode = 1; lid_i = 1;
        step(DB + 2); chk("R2 lid early", status[2], 0);
        step(1);      chk("R2 lid edge", status[2], 1);
        lid_i = 0; lid_mode = 0; step(2 * DB + 6); clear_all();
        dbnc_en = 0;

        // R3 lid modes
        for (int m = 0; m < 4; m++) begin
            lid_mode = 2'(m);
            lid_i = 1; step(4);
            chk($sformatf("R3 rise m%0d", m), status[2], m & 1);
            clear_all();
            lid_i = 0; step(4);
            chk($sformatf("R3 fall m%0d", m), status[2], (m >> 1) & 1);
            clear_all();
        end

        // R4 sleep button role
        slp_acpi_en = 0; slp_btn_n = 0; step(4);
        chk("R4 gated", status[1], 0);
        chk("R4 gpi", slp_gpi, 1);
        slp_btn_n = 1; step(3);
        chk("R4 gpi off", slp_gpi, 0);
        slp_acpi_en = 1; slp_btn_n = 0; step(4);
        chk("R4 event", status[1], 1);
        slp_btn_n = 1; step(3); clear_all();

        // R5 ring wake
        wake_en = 6'h08; ring_n = 0; step(4);
        chk("R5 status", status[3], 1);
        chk("R5 wake", wake_req, 1);
        wake_en = 0; #1 chk("R5 wake masked", wake_req, 0);
        ring_n = 1; step(3); clear_all();

        // R6 external SMI width sweep
        for (int L = 1; L <= MINL + 2; L++) begin
            xsmi_pin_n = 0; step(L);
            xsmi_pin_n = 1; step(8);
            chk($sformatf("R6 len%0d", L), status[5], (L >= MINL) ? 1 : 0);
            clear_all();
        end

        // R8 enable mask sweep against status {ring, power}
        pwr_btn_n = 0; ring_n = 0; step(4);
        pwr_btn_n = 1; ring_n = 1; step(3);
        for (int m = 0; m < 64; m++) begin
            smi_en = 6'(m); wake_en = 6'(63 - m);
            #1;
            chk($sformatf("R8 smi m%0d", m), smi_req, ((m & 9) != 0) ? 1 : 0);
            chk($sformatf("R8 wake m%0d", m), wake_req, (((63 - m) & 9) != 0) ? 1 : 0);
        end
        clear_all();

        // R9 serial IRQ drive window
        serirq_smi = 1; step(1); serirq_smi = 0;
        for (int k = 1; k <= HOLD; k++) begin
            chk($sformatf("R9 on%0d", k), xsmi_drive_low, 1);
            step(1);
        end
        chk("R9 off", xsmi_drive_low, 0);

        // R10 thermal throttle
        thrm_thr_en = 1; thrm_n = 0;
        step(1); chk("R10 early", throttle_req, 0);
        step(1); chk("R10 on", throttle_req, 1);
        step(1); chk("R10 status", status[4], 1);
        thrm_thr_en = 0; #1 chk("R10 off", throttle_req, 0);
        thrm_n = 1; step(3); clear_all();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule